// File: doc/BRIEF.md
# Dual-Current Fault Detector and Channel Selector

This block sits between the current-magnitude front end of a metering datapath and the power calculation. It takes two current magnitudes on a shared sample strobe: one from the phase (line) path and one from the neutral (return) path. On every strobe it decides which path feeds the power calculation and passes that path's magnitude on. It also raises a fault flag when the two paths disagree by more than one sixteenth (6.25 %) for a set number of consecutive samples.

While the paths disagree, the larger of the two is always used, so billing stays correct during tampering or a leakage fault. The comparison needs no divider: it scales the absolute difference by a power of two and compares it with the larger magnitude. When both magnitudes fall below a light-load floor (about 0.3 % of full scale), detection is turned off and the flag drops at once. This stops noise near zero load from raising a false fault. After reset the phase path is selected.

Top module: `fault_detect_sel`

## Requirements
- R1: After reset, `fault` is 0, `sel_neut` is 0 (phase path) and `sel_mag` is 0.
- R2: A sample is mismatched when its larger magnitude is at least `LOW_THR` and |phase − neut| · 2^`THR_SHIFT` is strictly greater than max(phase, neut). Equality is not a mismatch.
- R3: When the flag is 0, it is set on the clock edge of the `PERSIST`-th consecutive mismatched strobe. It is not set before that edge.
- R4: A strobe that is not mismatched, and that is not low-signal, restarts the rise count. After such a strobe, a full `PERSIST` run of mismatched strobes is needed again.
- R5: When the flag is 1, it clears on the edge of the `PERSIST`-th consecutive strobe that is neither mismatched nor low-signal. Any mismatched strobe restarts that count.
- R6: A strobe whose larger magnitude is below `LOW_THR` clears the flag on its edge and resets the persistence count, whatever the difference between the paths.
- R7: On a mismatched strobe, `sel_neut` becomes 1 if the neutral magnitude is larger and 0 if the phase magnitude is larger.
- R8: On a strobe that is not mismatched (including a low-signal strobe), `sel_neut` keeps its previous value.
- R9: On every strobe, `sel_mag` becomes the magnitude of the path chosen by the new `sel_neut` value (0 = phase, 1 = neutral) on that same strobe.
- R10: On cycles without `smp_vld`, `fault`, `sel_neut` and `sel_mag` hold their values, whatever the magnitude inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Strobe: both magnitudes are valid this cycle |
| phase_mag | input | MAG_W | Phase-path current magnitude |
| neut_mag | input | MAG_W | Neutral-path current magnitude |
| sel_neut | output | 1 | Selected path: 0 = phase, 1 = neutral |
| sel_mag | output | MAG_W | Magnitude of the selected path |
| fault | output | 1 | Persistent mismatch flag |

## Verification
The bench tests the exact ratio boundary, where a difference of exactly one sixteenth must not count. A design that used `>=` would raise the flag early on balanced loads. It tests runs that are one sample short of the persistence count and runs broken by one clean sample. A counter that is off by one, or that does not restart, would flag early or too late. Low-signal samples in the middle of a run must clear the flag at once, so a design that only masks new faults would fail. It also tests selection holding during clean samples and output stability between strobes, which catch a selector that drifts back to phase or updates on stale inputs.

// File: rtl/fdet_pkg.sv
// Package: shared result type for the dual-current fault detector.
// Assumes nothing beyond a standard SystemVerilog compile order (first).
package fdet_pkg;

    // Outcome of comparing one pair of magnitudes
    typedef struct packed {
        logic low;       // larger magnitude under the light-load floor
        logic mism;      // relative difference above threshold, not low
        logic neut_big;  // neutral magnitude strictly larger than phase
    } cmp_res_t;

endpackage

// File: rtl/fdet_compare.sv
// Module: fdet_compare
// Combinational ratio comparison of two magnitudes without division.
// A mismatch is |a-b| * 2^THR_SHIFT > max(a,b), suppressed when max < LOW_THR.
// Assumes unsigned magnitudes; the result is valid whenever inputs are.
module fdet_compare
    import fdet_pkg::*;
#(
    parameter int MAG_W     = 16,
    parameter int THR_SHIFT = 4,
    parameter int LOW_THR   = 197
) (
    input  logic [MAG_W-1:0] phase_mag,
    input  logic [MAG_W-1:0] neut_mag,
    output cmp_res_t         res
);

    localparam int EXT_W = MAG_W + THR_SHIFT;

    logic             neut_gt;
    logic [MAG_W-1:0] big;
    logic [MAG_W-1:0] diff;
    logic [EXT_W-1:0] diff_sc;
    logic [EXT_W-1:0] big_ext;

    // Order the pair and form the absolute difference
    always_comb begin
        neut_gt = neut_mag > phase_mag;
        big     = neut_gt ? neut_mag : phase_mag;
        diff    = neut_gt ? (neut_mag - phase_mag) : (phase_mag - neut_mag);
    end

    // Scale the difference by the threshold power of two and decide
    always_comb begin
        diff_sc      = {diff, {THR_SHIFT{1'b0}}};
        big_ext      = {{THR_SHIFT{1'b0}}, big};
        res.low      = big < MAG_W'(LOW_THR);
        res.mism     = !res.low && (diff_sc > big_ext);
        res.neut_big = neut_gt;
    end

endmodule

// File: rtl/fdet_persist.sv
// Module: fdet_persist
// Persistence timer for the fault flag. Counts consecutive strobes whose
// mismatch state differs from the current flag; toggles the flag after
// PERSIST of them. A low-signal strobe clears the flag and count at once.
// Assumes PERSIST >= 1 and that mism is never set together with low.
module fdet_persist #(
    parameter int PERSIST = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic low,
    input  logic mism,
    output logic fault
);

    localparam int CNT_W = (PERSIST < 2) ? 1 : $clog2(PERSIST);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             fault_q;

    // Advance the run count and toggle the flag at the end of a run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (smp_vld) begin
            if (low) begin
                cnt_q   <= '0;
                fault_q <= 1'b0;
            end else if (mism == fault_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q   <= '0;
                fault_q <= !fault_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign fault = fault_q;

    // R6
    low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && low) |=> !fault_q);

    // R3
    rise_on_mism_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> $past(smp_vld && mism));

    // R5
    fall_on_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(smp_vld && !mism));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/fdet_select.sv
// Module: fdet_select
// Channel selection register. On a mismatched strobe the larger path is
// chosen; otherwise the previous choice is held. The selected magnitude
// is registered on every strobe using the updated choice.
// Assumes the compare result is valid on strobe cycles.
module fdet_select #(
    parameter int MAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             mism,
    input  logic             neut_big,
    input  logic [MAG_W-1:0] phase_mag,
    input  logic [MAG_W-1:0] neut_mag,
    output logic             sel_neut,
    output logic [MAG_W-1:0] sel_mag
);

    logic             sel_q;
    logic             sel_nx;
    logic [MAG_W-1:0] mag_q;

    // Next selection: larger path on mismatch, else hold
    always_comb sel_nx = mism ? neut_big : sel_q;

    // Register the selection and the chosen magnitude on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            mag_q <= '0;
        end else if (smp_vld) begin
            sel_q <= sel_nx;
            mag_q <= sel_nx ? neut_mag : phase_mag;
        end
    end

    assign sel_neut = sel_q;
    assign sel_mag  = mag_q;

    // R7
    pick_larger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && mism) |=> (sel_q == $past(neut_big)));

    // R8
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !mism) |=> $stable(sel_q));

    // R9
    mag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> (mag_q == (sel_q ? $past(neut_mag) : $past(phase_mag))));

endmodule

// File: rtl/fault_detect_sel.sv
// Module: fault_detect_sel (top)
// Dual-current fault detector and selector. Compares phase and neutral
// magnitudes per strobe, keeps billing on the larger path while they
// disagree, and flags a persistent disagreement.
// Assumes both magnitudes arrive on the same strobe, already rectified.
module fault_detect_sel
    import fdet_pkg::*;
#(
    parameter int MAG_W     = 16,
    parameter int THR_SHIFT = 4,
    parameter int LOW_THR   = 197,
    parameter int PERSIST   = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [MAG_W-1:0] phase_mag,
    input  logic [MAG_W-1:0] neut_mag,
    output logic             sel_neut,
    output logic [MAG_W-1:0] sel_mag,
    output logic             fault
);

    cmp_res_t cmp;

    fdet_compare #(
        .MAG_W     (MAG_W),
        .THR_SHIFT (THR_SHIFT),
        .LOW_THR   (LOW_THR)
    ) i_compare (
        .phase_mag (phase_mag),
        .neut_mag  (neut_mag),
        .res       (cmp)
    );

    fdet_persist #(
        .PERSIST (PERSIST)
    ) i_persist (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .low     (cmp.low),
        .mism    (cmp.mism),
        .fault   (fault)
    );

    fdet_select #(
        .MAG_W (MAG_W)
    ) i_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .mism      (cmp.mism),
        .neut_big  (cmp.neut_big),
        .phase_mag (phase_mag),
        .neut_mag  (neut_mag),
        .sel_neut  (sel_neut),
        .sel_mag   (sel_mag)
    );

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(fault) && $stable(sel_neut) && $stable(sel_mag)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!fault && !sel_neut && sel_mag == '0));

endmodule

// File: tb/test_fault_detect_sel.sv
`timescale 1ns/1ps
module test_fault_detect_sel;

    localparam int MW = 16;
    localparam int SH = 4;
    localparam int LT = 200;
    localparam int PS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [MW-1:0] phase_mag = '0;
    logic [MW-1:0] neut_mag = '0;
    logic          sel_neut;
    logic [MW-1:0] sel_mag;
    logic          fault;

    int checks = 0;
    int errors = 0;

    // reference state
    int m_sel = 0, m_mag = 0, m_f = 0, m_c = 0;

    always #4 clk = ~clk;

    fault_detect_sel #(.MAG_W(MW), .THR_SHIFT(SH), .LOW_THR(LT), .PERSIST(PS))
    i_fault_detect_sel (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .phase_mag(phase_mag), .neut_mag(neut_mag),
        .sel_neut(sel_neut), .sel_mag(sel_mag), .fault(fault)
    );

    function automatic int is_low(int a, int b);
        int big = (a > b) ? a : b;
        return (big < LT) ? 1 : 0;
    endfunction

    function automatic int is_mism(int a, int b);
        int big = (a > b) ? a : b;
        int d   = (a > b) ? a - b : b - a;
        if (is_low(a, b) != 0) return 0;
        return ((d << SH) > big) ? 1 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(tag, "fault", int'(fault), m_f);
        chk(tag, "sel_neut", int'(sel_neut), m_sel);
        chk(tag, "sel_mag", int'(sel_mag), m_mag);
    endtask

    // one strobe, then reference update and compare
    task automatic apply(int a, int b, string tag);
        int mm, lo;
        @(negedge clk);
        phase_mag = MW'(a);
        neut_mag  = MW'(b);
        smp_vld   = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        mm = is_mism(a, b);
        lo = is_low(a, b);
        if (mm != 0) m_sel = (b > a) ? 1 : 0;
        m_mag = (m_sel != 0) ? b : a;
        if (lo != 0) begin
            m_f = 0; m_c = 0;
        end else if (mm == m_f) begin
            m_c = 0;
        end else begin
            m_c++;
            if (m_c == PS) begin m_f = 1 - m_f; m_c = 0; end
        end
        chk_all(tag);
    endtask

    // idle cycle with junk on the magnitude inputs
    task automatic idle(string tag);
        @(negedge clk);
        phase_mag = MW'($urandom);
        neut_mag  = MW'($urandom);
        smp_vld   = 1'b0;
        @(negedge clk);
        chk_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_all("R1");
        rst_n = 1'b1;

        // R3 / R7: neutral high, flag after exactly PS strobes
        for (int i = 0; i < PS; i++) apply(1000, 2000, "R3");
        chk("R3", "fault_after_run", int'(fault), 1);
        chk("R7", "neutral_chosen", int'(sel_neut), 1);

        // R2 / R5: exact boundary counts as clean; flag clears after PS
        for (int i = 0; i < PS; i++) apply(1600, 1500, "R2");
        chk("R5", "cleared", int'(fault), 0);
        // R8: clean samples kept the neutral selection; R9 magnitude
        chk("R8", "sel_held", int'(sel_neut), 1);
        chk("R9", "mag_neut", int'(sel_mag), 1500);

        // R2: one past the boundary is a mismatch (phase larger)
        apply(1600, 1499, "R2");
        chk("R7", "phase_chosen", int'(sel_neut), 0);

        // R4: a clean strobe restarts the count
        for (int i = 0; i < PS - 2; i++) apply(1600, 1499, "R4");
        apply(3000, 3000, "R4");
        for (int i = 0; i < PS - 1; i++) apply(1000, 3000, "R4");
        chk("R4", "not_yet", int'(fault), 0);
        apply(1000, 3000, "R4");
        chk("R4", "after_full_run", int'(fault), 1);

        // R10: idle cycles with junk inputs
        for (int i = 0; i < 4; i++) idle("R10");

        // R6: low-signal strobe clears at once, selection held (R8)
        apply(199, 0, "R6");
        chk("R6", "low_clear", int'(fault), 0);
        chk("R8", "low_hold", int'(sel_neut), 1);
        apply(200, 0, "R7");

        // random bursts
        for (int k = 0; k < 120; k++) begin
            int mode = int'($urandom % 4);
            int len  = 1 + int'($urandom % 9);
            for (int j = 0; j < len; j++) begin
                int base = 300 + int'($urandom % 60000);
                int a, b;
                case (mode)
                    0: begin a = base; b = base - base / 40; end
                    1: begin b = base; a = base - base / 8; end
                    2: begin a = base; b = base - base / 8; end
                    default: begin a = int'($urandom % LT); b = int'($urandom % LT); end
                endcase
                if ($urandom % 2 == 0 && mode == 0) begin int t = a; a = b; b = t; end
                apply(a, b, "R9");
                if ($urandom % 5 == 0) idle("R10");
            end
        end

        // R1 again: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_sel = 0; m_mag = 0; m_f = 0; m_c = 0;
        chk_all("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule